// File: doc/BRIEF.md
# Converter Result Output Port

This block is the digital back end of a 16-bit successive-approximation converter. It receives a finished conversion word from the converter core. It flags the conversion in progress on a busy output. It applies the selected output coding when it captures the word and then presents the word in one of two ways. The first is a parallel data bus that is read with chip-select and read-enable strobes. The second is a serial port that reuses some of the same data pins.

When the serial port is selected, three pins of the data bus become static strap inputs. One chooses whether the port makes its own shift clock or follows an external clock. One sets the polarity of the frame-sync output. One inverts the active edge of the shift clock. The pads themselves lie outside this block, so every shared pin appears as an output value, an output enable and, where needed, an input.

Top module: `sar_result_port`

## Requirements
- R1: `busy` rises in the cycle after `conv_start` is sampled high and falls in the cycle after `conv_done` is sampled high.
- R2: With `straight_sel` high the captured word equals the converter result (full scale FFFF, midscale 8000, zero 0000). With it low only bit 15 is inverted, giving two's complement (7FFF, 0000, 8000).
- R3: There is no pipeline delay. The word presented after `busy` falls belongs to the conversion that just ended, and it does not change until the next `conv_done`.
- R4: With `serial_sel` low, `pin_oe` is FFFF and `pin_o` carries the captured word only while `cs_n` and `rd_n` are both low. Otherwise `pin_oe` is 0000.
- R5: With `serial_sel` high, `pin_oe[15:4]` is always 0. Pins 3:0 remain outputs: they drive 0 with their enables high while `cs_n` and `rd_n` are both low.
- R6: In serial master mode (`strap_pins[0]` low), `sclk_oe` is high and the port sends the 16 bits MSB first. It uses one bit per 4 system clocks, and `sdout` is stable while the effective shift clock is high.
- R7: `sync` is active for exactly the 16 bits of a frame. With `strap_pins[1]` low, active means high. With it high, active means low.
- R8: `strap_pins[2]` high inverts `sclk_out` in master mode and the sensed `sclk_in` in slave mode. The effective clock is the pin XOR `strap_pins[2]`, and data is valid on its rising edge.
- R9: In slave mode (`strap_pins[0]` high), `sclk_oe` is low. The k-th rising effective edge of `sclk_in` after a capture puts bit 16-k on `sdout`. Edges after the 16th give 0.
- R10: With `serial_sel` low, `sync`, `sdout` and `sclk_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Conversion start strobe |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 16 | Saturated straight-binary result from the core |
| busy | output | 1 | Conversion in progress |
| cs_n | input | 1 | Parallel chip select, active low |
| rd_n | input | 1 | Parallel read enable, active low |
| straight_sel | input | 1 | High: straight binary, low: two's complement |
| serial_sel | input | 1 | High: serial port, low: parallel bus |
| strap_pins | input | 3 | Input side of data pins 6:4 (clock source, sync polarity, clock inversion) |
| pin_o | output | 16 | Data pin output values |
| pin_oe | output | 16 | Data pin output enables |
| sclk_in | input | 1 | External shift clock (slave mode) |
| sclk_out | output | 1 | Generated shift clock (master mode) |
| sclk_oe | output | 1 | Shift clock pin enable |
| sdout | output | 1 | Serial data out |
| sync | output | 1 | Frame sync |

## Verification
The assertions take for granted that `conv_done` arrives only while a conversion is in progress and not in the middle of a serial frame. They also assume the strap pins and `serial_sel` stay fixed while a frame runs, and that a slave clock holds each level for several system clocks. The stimulus keeps to these limits. It changes straps only while the port is idle, and it changes them together with the idle level of `sclk_in`, so the sensed clock never shows a false edge. It holds each external clock level for at least four cycles. Random result words and directed full-scale, midscale and zero codes go through both codings, both clock sources and all four polarity pairs.

// File: rtl/sarp_pkg.sv
// Shared definitions for the converter result port.
// Assumes: the three strap pins are static while the serial port is in use.
package sarp_pkg;
    // Index of each strap inside strap_pins (pins 4, 5 and 6 of the data bus).
    localparam int unsigned STRAP_EXT  = 0;
    localparam int unsigned STRAP_SYNC = 1;
    localparam int unsigned STRAP_INV  = 2;
    // Number of low data pins that stay outputs in serial mode.
    localparam int unsigned LOW_OUT    = 4;

    typedef struct packed {
        logic ext_clk;   // follow external shift clock
        logic sync_low;  // frame sync active low
        logic sclk_inv;  // invert shift clock
    } strap_t;
endpackage

// File: rtl/sarp_result_latch.sv
// Captures the converter result with the chosen coding and tracks busy.
// Assumes: conv_done arrives only after conv_start; coding select is static
// around conv_done.
module sarp_result_latch #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start,
    input  logic         conv_done,
    input  logic [W-1:0] conv_result,
    input  logic         straight_sel,
    output logic         busy,
    output logic [W-1:0] result_q,
    output logic         load_q
);
    logic [W-1:0] coded;

    // Coding: two's complement flips only the top bit.
    always_comb begin
        coded = conv_result;
        if (!straight_sel) coded[W-1] = ~conv_result[W-1];
    end

    // Busy flag and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            result_q <= '0;
        end else if (conv_done) begin
            busy     <= 1'b0;
            result_q <= coded;
        end else if (conv_start) begin
            busy     <= 1'b1;
        end
    end

    // One-cycle strobe telling the serial side a new word is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= conv_done;
    end

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !busy); // R1
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_done) |=> busy); // R1
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(result_q)); // R3
endmodule

// File: rtl/sarp_par_bus.sv
// Shared-pin multiplexer: parallel read bus or serial straps.
// Assumes: pads outside this block combine pin_o/pin_oe into bidirectional pins.
module sarp_par_bus
    import sarp_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         serial_sel,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic [W-1:0] result_q,
    input  logic [2:0]   strap_pins,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe,
    output strap_t       straps
);
    logic rd_act;

    // Read window of the parallel bus.
    always_comb rd_act = !cs_n && !rd_n;

    for (genvar g = 0; g < W; g++) begin : g_lane
        if (g < LOW_OUT) begin : g_low
            // Low lanes stay outputs in both modes; zero in serial mode.
            always_comb begin
                pin_oe[g] = rd_act;
                pin_o[g]  = serial_sel ? 1'b0 : result_q[g];
            end
        end else begin : g_high
            // Upper lanes float in serial mode (some become strap inputs).
            always_comb begin
                pin_oe[g] = rd_act && !serial_sel;
                pin_o[g]  = serial_sel ? 1'b0 : result_q[g];
            end
        end
    end

    // Straps take effect only when the serial port is selected.
    always_comb begin
        straps.ext_clk  = serial_sel && strap_pins[STRAP_EXT];
        straps.sync_low = serial_sel && strap_pins[STRAP_SYNC];
        straps.sclk_inv = serial_sel && strap_pins[STRAP_INV];
    end

    AST_SER_HI_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        serial_sel |-> (pin_oe[W-1:LOW_OUT] == '0)); // R5
    AST_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (pin_oe == '0)); // R4
endmodule

// File: rtl/sarp_ser_shifter.sv
// Serial frame engine: MSB-first shift with sync, master or slave clocking.
// Assumes: a new load never arrives during a running frame; slave clock
// levels last longer than SYNC_STAGES+1 system clocks.
module sarp_ser_shifter
    import sarp_pkg::*;
#(
    parameter int unsigned W           = 16,
    parameter int unsigned DIV         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         serial_sel,
    input  strap_t       straps,
    input  logic         load,
    input  logic [W-1:0] result_q,
    input  logic         sclk_in,
    output logic         sclk_out,
    output logic         sclk_oe,
    output logic         sdout,
    output logic         sync
);
    localparam int unsigned CNT_W = $clog2(W + 2);
    localparam int unsigned PH_W  = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(W);
    localparam logic [CNT_W-1:0] DONE_C  = CNT_W'(W + 1);
    localparam logic [PH_W-1:0]  PH_HALF = PH_W'(DIV / 2);
    localparam logic [PH_W-1:0]  PH_END  = PH_W'(DIV - 1);

    logic [SYNC_STAGES:0] sy;
    logic [W-1:0]         sh;
    logic [CNT_W-1:0]     cnt;
    logic [PH_W-1:0]      ph;
    logic                 armed, sdo, master, in_frame, raw, tick, ext_edge;

    // Mode and frame decode.
    always_comb begin
        master   = serial_sel && !straps.ext_clk;
        in_frame = (cnt != '0) && (cnt <= LAST_C);
        raw      = master && in_frame && (ph >= PH_HALF);
        ext_edge = sy[SYNC_STAGES-1] && !sy[SYNC_STAGES];
        if (master) tick = armed && (cnt != DONE_C) && (ph == '0);
        else        tick = serial_sel && straps.ext_clk && armed && ext_edge;
    end

    // Resynchronise the effective external clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sy <= '0;
        else        sy <= {sy[SYNC_STAGES-1:0], sclk_in ^ straps.sclk_inv};
    end

    // Divider phase for the generated clock.
    always_ff @(posedge clk) begin
        if (!rst_n || (load && serial_sel)) ph <= '0;
        else if (master && armed && cnt != DONE_C)
            ph <= (ph == PH_END) ? '0 : ph + 1'b1;
    end

    // Shift register, bit counter and data output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            cnt   <= DONE_C;
            sdo   <= 1'b0;
            armed <= 1'b0;
        end else if (load && serial_sel) begin
            sh    <= result_q;
            cnt   <= '0;
            armed <= 1'b1;
        end else if (tick) begin
            sdo <= sh[W-1];
            sh  <= sh << 1;
            if (cnt != DONE_C) cnt <= cnt + 1'b1;
        end
    end

    // Pin outputs.
    always_comb begin
        sclk_oe  = master;
        sclk_out = master && (raw ^ straps.sclk_inv);
        sdout    = serial_sel && sdo;
        sync     = serial_sel && (in_frame ^ straps.sync_low);
    end

    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == LAST_C && !load) |=> !in_frame); // R7
    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        raw |-> $stable(sdo)); // R6
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt == DONE_C) |-> !sdo); // R9
    AST_NO_DRIVE_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_sel |-> (!sync && !sdout && !sclk_oe)); // R10
endmodule

// File: rtl/sar_result_port.sv
// Top of the converter result output port: capture, parallel bus, serial port.
// Assumes: conv_result is already saturated straight binary from the core.
module sar_result_port #(
    parameter int unsigned W           = 16,
    parameter int unsigned DIV         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start,
    input  logic         conv_done,
    input  logic [W-1:0] conv_result,
    output logic         busy,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         straight_sel,
    input  logic         serial_sel,
    input  logic [2:0]   strap_pins,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe,
    input  logic         sclk_in,
    output logic         sclk_out,
    output logic         sclk_oe,
    output logic         sdout,
    output logic         sync
);
    logic [W-1:0]     result_q;
    logic             load_q;
    sarp_pkg::strap_t straps;

    sarp_result_latch #(.W(W)) u_latch (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .straight_sel(straight_sel),
        .busy(busy), .result_q(result_q), .load_q(load_q)
    );

    sarp_par_bus #(.W(W)) u_bus (
        .clk(clk), .rst_n(rst_n), .serial_sel(serial_sel), .cs_n(cs_n), .rd_n(rd_n),
        .result_q(result_q), .strap_pins(strap_pins),
        .pin_o(pin_o), .pin_oe(pin_oe), .straps(straps)
    );

    sarp_ser_shifter #(.W(W), .DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_ser (
        .clk(clk), .rst_n(rst_n), .serial_sel(serial_sel), .straps(straps),
        .load(load_q), .result_q(result_q), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdout(sdout), .sync(sync)
    );
endmodule

// File: tb/sar_result_port_bench.sv
// Self-checking bench: directed codes plus seeded random words.
module sar_result_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 0, conv_done = 0, cs_n = 1, rd_n = 1;
    logic straight_sel = 1, serial_sel = 0, sclk_in = 0;
    logic [15:0] conv_result = '0;
    logic [2:0]  strap_pins = '0;
    logic        busy, sclk_out, sclk_oe, sdout, sync;
    logic [15:0] pin_o, pin_oe;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sar_result_port u_sar_result_port (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .busy(busy), .cs_n(cs_n), .rd_n(rd_n),
        .straight_sel(straight_sel), .serial_sel(serial_sel), .strap_pins(strap_pins),
        .pin_o(pin_o), .pin_oe(pin_oe), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sdout(sdout), .sync(sync)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expcode(input logic [15:0] r, input bit st);
        return st ? r : {~r[15], r[14:0]};
    endfunction

    task automatic convert(input logic [15:0] r);
        @(negedge clk) conv_start = 1;
        @(negedge clk) conv_start = 0;
        chk(busy == 1'b1, "R1 busy rise", busy, 1);
        repeat (2) @(negedge clk);
        conv_result = r; conv_done = 1;
        @(negedge clk) conv_done = 0;
        chk(busy == 1'b0, "R1 busy fall", busy, 0);
    endtask

    task automatic par_read(input logic [15:0] exp, input string tag);
        @(negedge clk) begin cs_n = 0; rd_n = 0; end
        #1;
        chk(pin_oe == 16'hFFFF, "R4 read enable", pin_oe, 16'hFFFF);
        chk(pin_o == exp, tag, pin_o, exp);
        rd_n = 1; #1;
        chk(pin_oe == 16'h0000, "R4 float after read", pin_oe, 0);
        cs_n = 1;
    endtask

    task automatic master_frame(input bit pol, input bit inv);
        logic [15:0] r, w, e;
        int n = 0, first = -1, last = -1;
        bit prev = 0, eff, sync_ok = 1;
        @(negedge clk) begin serial_sel = 1; strap_pins = {inv, pol, 1'b0}; sclk_in = inv; end
        repeat (4) @(negedge clk);
        chk(sync == pol, "R7 sync idle level", sync, pol);
        chk(sclk_oe == 1'b1, "R6 master drives clock", sclk_oe, 1);
        r = 16'($urandom); e = expcode(r, straight_sel); w = '0;
        convert(r);
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            eff = sclk_out ^ inv;
            if (eff && !prev) begin
                w = {w[14:0], sdout}; n++;
                if (first < 0) first = c;
                last = c;
                if (sync != !pol) sync_ok = 0;
            end
            prev = eff;
        end
        chk(n == 16, "R6 bit count", n, 16);
        chk(w == e, "R8 master word MSB first", w, e);
        chk(last - first == 60, "R6 bit period", last - first, 60);
        chk(sync_ok, "R7 sync active during bits", sync_ok, 1);
        chk(sync == pol, "R7 sync inactive after frame", sync, pol);
        @(negedge clk) begin cs_n = 0; rd_n = 0; end
        #1;
        chk(pin_oe == 16'h000F, "R5 serial pin enables", pin_oe, 16'h000F);
        chk(pin_o[3:0] == 4'h0, "R5 low pins zero", pin_o[3:0], 0);
        cs_n = 1; rd_n = 1;
    endtask

    task automatic slave_frame(input bit pol, input bit inv);
        logic [15:0] r, w, e;
        @(negedge clk) begin serial_sel = 1; strap_pins = {inv, pol, 1'b1}; sclk_in = inv; end
        repeat (4) @(negedge clk);
        chk(sclk_oe == 1'b0, "R9 slave leaves clock pin", sclk_oe, 0);
        r = 16'($urandom); e = expcode(r, straight_sel); w = '0;
        convert(r);
        repeat (4) @(negedge clk);
        for (int k = 0; k < 18; k++) begin
            sclk_in = ~inv;
            repeat (6) @(negedge clk);
            if (k < 16) begin
                w = {w[14:0], sdout};
                if (sync != !pol) chk(0, "R7 slave sync active", sync, !pol);
            end else begin
                chk(sdout == 1'b0, "R9 extra edge zero", sdout, 0);
                chk(sync == pol, "R7 slave sync ended", sync, pol);
            end
            sclk_in = inv;
            repeat (4) @(negedge clk);
        end
        chk(w == e, "R9 slave word", w, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(pin_oe == 16'h0, "R4 reset float", pin_oe, 0);
        chk(sync == 1'b0 && sclk_oe == 1'b0 && sdout == 1'b0, "R10 parallel serial idle",
            {sync, sclk_oe, sdout}, 0);
        // Directed codes in both codings (R2).
        for (int s = 0; s < 2; s++) begin
            straight_sel = (s == 0);
            convert(16'hFFFF); par_read(expcode(16'hFFFF, straight_sel), "R2 full scale");
            convert(16'h0000); par_read(expcode(16'h0000, straight_sel), "R2 zero");
            convert(16'h8000); par_read(expcode(16'h8000, straight_sel), "R2 midscale");
        end
        // Random words: each read belongs to the last conversion (R3).
        for (int i = 0; i < 12; i++) begin
            r = 16'($urandom);
            straight_sel = 1'($urandom);
            convert(r);
            repeat (3) @(negedge clk);
            par_read(expcode(r, straight_sel), "R3 latest result");
            chk(sync == 1'b0 && sdout == 1'b0 && sclk_oe == 1'b0, "R10 no serial in parallel",
                {sync, sdout, sclk_oe}, 0);
        end
        for (int p = 0; p < 4; p++) begin
            straight_sel = p[0];
            master_frame(p[0], p[1]);
            slave_frame(p[0], p[1]);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule